// File: doc/BRIEF.md
# Prioritized Voice Interrupt Queue

This block collects interrupt requests from up to 31 synthesizer voices and hands them to the host one at a time. Each voice can raise two kinds of event: a wavetable end-of-sample event and a volume-ramp event. Each kind has its own pending mask. The host never reads the masks directly. It writes the interrupt-status function code (0x8F) into the function-select register, and that write dequeues exactly one source. Wavetable events are served before any ramp event. Within a mask, the lowest voice number goes first. The write also loads an encoded status byte, which the host then reads as often as it likes.

When a source is dequeued, the block emits a one-cycle clear pulse toward that voice, so the voice can drop the interrupt flag in its own control register. The block also maintains the card-level interrupt status byte. Bit 5 of that byte mirrors "any wavetable event pending" and bit 6 mirrors "any ramp event pending". The other bits are set and cleared by the rest of the card. The interrupt line stays up for as long as any bit of that byte is set. A card reset strobe empties the masks and the card status byte.

Top module: `voice_irq_queue`

## Requirements
- R1: A dequeue happens only in a cycle where `fsel_wr` is high and `fsel_data` equals 0x8F. A select write with any other code, or 0x8F on `fsel_data` without `fsel_wr`, leaves `irq_code`, both masks and the clear outputs unchanged (the clear outputs stay zero).
- R2: A dequeue takes from the wavetable mask whenever it is non-empty, and from the ramp mask only when the wavetable mask is empty. In either mask, the lowest-numbered pending voice (0..30) is taken.
- R3: Dequeuing wavetable voice v clears that mask bit. At the next clock edge, `irq_code` becomes {3'b011, v[4:0]} (0x60 | v), and `wave_ack[v]` is high for exactly one cycle.
- R4: Dequeuing ramp voice v clears that mask bit. At the next clock edge, `irq_code` becomes {3'b100, v[4:0]} (0x80 | v), and `ramp_ack[v]` is high for exactly one cycle.
- R5: A dequeue with both masks empty loads `irq_code` with 0xE8 and raises no clear output.
- R6: `card_irq_stat[5]` is 1 exactly when the wavetable mask is non-empty, and `card_irq_stat[6]` is 1 exactly when the ramp mask is non-empty. The other bits are set by `host_stat_set` and cleared by `host_stat_clr`; a bit named in both is set. Bits 5 and 6 of both host vectors are ignored.
- R7: `irq_out` is high exactly when `card_irq_stat` is non-zero. It falls only when that byte is all zero.
- R8: A `card_flush` cycle empties both masks and zeroes `card_irq_stat`. Events, host set bits and any dequeue in that same cycle are dropped, and `irq_code` keeps its value.
- R9: If a voice's event pulse and the dequeue of that same voice fall in one cycle, its mask bit stays set. The dequeue still reports the voice, and a later dequeue reports it again.
- R10: After `rst_n` is released, both masks are empty, `card_irq_stat` is 0, `irq_out` is 0, both clear outputs are 0 and `irq_code` is 0xE8.
- R11: Event pulses on several voices in one cycle all become pending, and are dequeued later in ascending voice order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| voice_wave_evt | input | 31 | Per-voice wavetable event pulses |
| voice_ramp_evt | input | 31 | Per-voice volume-ramp event pulses |
| fsel_wr | input | 1 | Function-select register write strobe |
| fsel_data | input | 8 | Function code being written |
| card_flush | input | 1 | Card reset strobe (reset bit written low) |
| host_stat_set | input | 8 | Set strobes for the other card status bits |
| host_stat_clr | input | 8 | Clear strobes for the other card status bits |
| irq_code | output | 8 | Last loaded encoded interrupt status byte |
| wave_ack | output | 31 | One-cycle pulse that clears a voice's wave-control IRQ flag |
| ramp_ack | output | 31 | One-cycle pulse that clears a voice's ramp-control IRQ flag |
| card_irq_stat | output | 8 | Card-level interrupt status byte |
| irq_out | output | 1 | Interrupt request line |

## Verification
The bench targets the priority order directly. It makes wavetable and ramp events pending together on voice 0 and voice 30. A design that looked at the masks in the wrong order, or that scanned from the top voice down, would report the wrong code. It drains each mask down to its last bit. A design that cleared bit 5 or 6 too early, or too late, would leave the interrupt line stuck high or drop it while the host status bits were still set. It also fires a voice's event in the same cycle that voice is dequeued, and fires a card flush together with a dequeue and fresh events. A design that let the clear win, or let the flush lose, would lose an interrupt or let a stale one survive the reset.

// File: rtl/vq_pkg.sv
package vq_pkg;
    localparam logic [7:0] FN_IRQ_POP   = 8'h8F;
    localparam logic [2:0] TAG_WAVE     = 3'b011;
    localparam logic [2:0] TAG_RAMP     = 3'b100;
    localparam logic [7:0] CODE_IDLE    = 8'hE8;
    localparam int         CODE_VOICE_W = 5;
    localparam int         BIT_WAVE_BUSY = 5;
    localparam int         BIT_RAMP_BUSY = 6;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_WAVE,
        SRC_RAMP
    } src_e;
endpackage

// File: rtl/vq_lowest_pick.sv
// Finds the lowest set bit of a request vector: index, one-hot and found flag.
module vq_lowest_pick #(
    parameter int N = 31,
    parameter int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx,
    output logic [N-1:0] onehot
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = W'(i);
            end
        end
    end

    assign found  = |req;
    assign onehot = req & (~req + ONE);
endmodule

// File: rtl/vq_pending_mask.sv
// One pending-interrupt mask: sets win over clears, flush wins over everything.
module vq_pending_mask #(
    parameter int N = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] mask_o,
    output logic         busy_nx_o
);
    typedef struct packed {
        logic [N-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.mask = '0;
        end else begin
            st_d.mask = (st_q.mask & ~clr_vec) | set_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o    = st_q.mask;
    assign busy_nx_o = |st_d.mask;

    AST_SET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && (set_vec != '0)) |=> ((mask_o & $past(set_vec)) == $past(set_vec))) // R9
        else $error("AST_SET_KEPT");

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (mask_o == '0)) // R8
        else $error("AST_FLUSH_EMPTY");
endmodule

// File: rtl/vq_card_status.sv
// Card-level interrupt status byte and the interrupt line derived from it.
module vq_card_status #(
    parameter int SW        = 8,
    parameter int WAVE_BIT  = 5,
    parameter int RAMP_BIT  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [SW-1:0] ext_set,
    input  logic [SW-1:0] ext_clr,
    input  logic          wave_busy_nx,
    input  logic          ramp_busy_nx,
    output logic [SW-1:0] stat_o,
    output logic          irq_o
);
    localparam logic [SW-1:0] MIRROR_MASK = (SW'(1) << WAVE_BIT) | (SW'(1) << RAMP_BIT);

    typedef struct packed {
        logic [SW-1:0] other;
        logic [SW-1:0] stat;
        logic          irq;
    } card_state_t;

    card_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.other = '0;
        end else begin
            st_d.other = ((st_q.other & ~ext_clr) | ext_set) & ~MIRROR_MASK;
        end
        st_d.stat           = st_d.other;
        st_d.stat[WAVE_BIT] = wave_busy_nx & !flush;
        st_d.stat[RAMP_BIT] = ramp_busy_nx & !flush;
        st_d.irq            = |st_d.stat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign irq_o  = st_q.irq;

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (stat_o != '0)) // R7
        else $error("AST_IRQ_LEVEL");

    AST_IRQ_FALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> (stat_o == '0)) // R7
        else $error("AST_IRQ_FALL_ZERO");

    AST_CARD_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (stat_o == '0)) // R8
        else $error("AST_CARD_FLUSH");
endmodule

// File: rtl/voice_irq_queue.sv
// Two pending masks, one strict-priority dequeue per 0x8F select write.
module voice_irq_queue
    import vq_pkg::*;
#(
    parameter int NUM_VOICES = 31,
    parameter int STAT_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_VOICES-1:0] voice_wave_evt,
    input  logic [NUM_VOICES-1:0] voice_ramp_evt,
    input  logic                  fsel_wr,
    input  logic [7:0]            fsel_data,
    input  logic                  card_flush,
    input  logic [STAT_W-1:0]     host_stat_set,
    input  logic [STAT_W-1:0]     host_stat_clr,
    output logic [7:0]            irq_code,
    output logic [NUM_VOICES-1:0] wave_ack,
    output logic [NUM_VOICES-1:0] ramp_ack,
    output logic [STAT_W-1:0]     card_irq_stat,
    output logic                  irq_out
);
    localparam int VW = (NUM_VOICES > 1) ? $clog2(NUM_VOICES) : 1;

    typedef struct packed {
        logic [7:0]            code;
        logic [NUM_VOICES-1:0] wack;
        logic [NUM_VOICES-1:0] rack;
    } q_state_t;

    q_state_t st_d, st_q;

    logic [NUM_VOICES-1:0] wave_mask, ramp_mask;
    logic                  wave_busy_nx, ramp_busy_nx;
    logic                  wave_found, ramp_found;
    logic [VW-1:0]         wave_idx, ramp_idx;
    logic [NUM_VOICES-1:0] wave_oh, ramp_oh;
    logic [NUM_VOICES-1:0] wave_take, ramp_take;
    logic                  pop_req;
    src_e                  src;

    vq_lowest_pick #(.N(NUM_VOICES), .W(VW)) u_pick_wave (
        .req    (wave_mask),
        .found  (wave_found),
        .idx    (wave_idx),
        .onehot (wave_oh)
    );

    vq_lowest_pick #(.N(NUM_VOICES), .W(VW)) u_pick_ramp (
        .req    (ramp_mask),
        .found  (ramp_found),
        .idx    (ramp_idx),
        .onehot (ramp_oh)
    );

    always_comb begin
        pop_req = fsel_wr && (fsel_data == FN_IRQ_POP) && !card_flush;
        if (!pop_req) begin
            src = SRC_NONE;
        end else if (wave_found) begin
            src = SRC_WAVE;
        end else if (ramp_found) begin
            src = SRC_RAMP;
        end else begin
            src = SRC_NONE;
        end
        wave_take = (src == SRC_WAVE) ? wave_oh : '0;
        ramp_take = (src == SRC_RAMP) ? ramp_oh : '0;
    end

    vq_pending_mask #(.N(NUM_VOICES)) u_mask_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (card_flush),
        .set_vec   (voice_wave_evt),
        .clr_vec   (wave_take),
        .mask_o    (wave_mask),
        .busy_nx_o (wave_busy_nx)
    );

    vq_pending_mask #(.N(NUM_VOICES)) u_mask_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (card_flush),
        .set_vec   (voice_ramp_evt),
        .clr_vec   (ramp_take),
        .mask_o    (ramp_mask),
        .busy_nx_o (ramp_busy_nx)
    );

    vq_card_status #(
        .SW       (STAT_W),
        .WAVE_BIT (BIT_WAVE_BUSY),
        .RAMP_BIT (BIT_RAMP_BUSY)
    ) u_card (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (card_flush),
        .ext_set      (host_stat_set),
        .ext_clr      (host_stat_clr),
        .wave_busy_nx (wave_busy_nx),
        .ramp_busy_nx (ramp_busy_nx),
        .stat_o       (card_irq_stat),
        .irq_o        (irq_out)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wack = wave_take;
        st_d.rack = ramp_take;
        if (pop_req) begin
            unique case (src)
                SRC_WAVE: st_d.code = {TAG_WAVE, CODE_VOICE_W'(wave_idx)};
                SRC_RAMP: st_d.code = {TAG_RAMP, CODE_VOICE_W'(ramp_idx)};
                default:  st_d.code = CODE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.code <= CODE_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_code = st_q.code;
    assign wave_ack = st_q.wack;
    assign ramp_ack = st_q.rack;

    AST_POP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !(fsel_wr && (fsel_data == FN_IRQ_POP)) |=> ($stable(irq_code) && (wave_ack == '0) && (ramp_ack == '0))) // R1
        else $error("AST_POP_GATED");

    AST_WAVE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel_wr && (fsel_data == FN_IRQ_POP) && !card_flush && (wave_mask != '0))
            |=> ((ramp_ack == '0) && $onehot(wave_ack))) // R2
        else $error("AST_WAVE_FIRST");

    AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wave_ack, ramp_ack})) // R3
        else $error("AST_ONE_ACK");

    AST_WAVE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_ack != '0) |-> (irq_code[7:5] == TAG_WAVE)) // R3
        else $error("AST_WAVE_CODE");

    AST_RAMP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_ack != '0) |-> (irq_code[7:5] == TAG_RAMP)) // R4
        else $error("AST_RAMP_CODE");

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel_wr && (fsel_data == FN_IRQ_POP) && !card_flush && (wave_mask == '0) && (ramp_mask == '0))
            |=> ((irq_code == CODE_IDLE) && (wave_ack == '0) && (ramp_ack == '0))) // R5
        else $error("AST_IDLE_CODE");

    AST_MIRROR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (card_irq_stat[BIT_WAVE_BUSY] == (wave_mask != '0)) &&
        (card_irq_stat[BIT_RAMP_BUSY] == (ramp_mask != '0))) // R6
        else $error("AST_MIRROR_BITS");

    AST_FLUSH_HOLDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        card_flush |=> ($stable(irq_code) && (wave_ack == '0) && (ramp_ack == '0))) // R8
        else $error("AST_FLUSH_HOLDS_CODE");
endmodule

// File: tb/voice_irq_queue_test.sv
`timescale 1ns/1ps
module voice_irq_queue_test;
    localparam int NV = 31;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NV-1:0] voice_wave_evt = '0;
    logic [NV-1:0] voice_ramp_evt = '0;
    logic          fsel_wr = 1'b0;
    logic [7:0]    fsel_data = '0;
    logic          card_flush = 1'b0;
    logic [7:0]    host_stat_set = '0;
    logic [7:0]    host_stat_clr = '0;
    logic [7:0]    irq_code;
    logic [NV-1:0] wave_ack;
    logic [NV-1:0] ramp_ack;
    logic [7:0]    card_irq_stat;
    logic          irq_out;

    voice_irq_queue uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .voice_wave_evt (voice_wave_evt),
        .voice_ramp_evt (voice_ramp_evt),
        .fsel_wr        (fsel_wr),
        .fsel_data      (fsel_data),
        .card_flush     (card_flush),
        .host_stat_set  (host_stat_set),
        .host_stat_clr  (host_stat_clr),
        .irq_code       (irq_code),
        .wave_ack       (wave_ack),
        .ramp_ack       (ramp_ack),
        .card_irq_stat  (card_irq_stat),
        .irq_out        (irq_out)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic [31:0]   due;
        logic [7:0]    code;
        logic [NV-1:0] wack;
        logic [NV-1:0] rack;
        logic [7:0]    card;
        logic          irq;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    bit    reported = 0;

    // Reference model state, built from the requirements
    logic [NV-1:0] m_wave = '0;
    logic [NV-1:0] m_ramp = '0;
    logic [7:0]    m_other = '0;
    logic [7:0]    m_code = 8'hE8;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outputs
    task automatic drive(input logic [NV-1:0] ws, input logic [NV-1:0] rs,
                         input logic sw, input logic [7:0] sd, input logic fl,
                         input logic [7:0] es, input logic [7:0] ec, input string tag);
        exp_t e;
        logic [NV-1:0] wk;
        logic [NV-1:0] rk;
        logic          done;
        @(negedge clk);
        voice_wave_evt = ws;
        voice_ramp_evt = rs;
        fsel_wr        = sw;
        fsel_data      = sd;
        card_flush     = fl;
        host_stat_set  = es;
        host_stat_clr  = ec;
        wk = '0;
        rk = '0;
        if (fl) begin
            m_wave  = '0;
            m_ramp  = '0;
            m_other = '0;
        end else begin
            if (sw && sd == 8'h8F) begin
                done = 0;
                for (int v = 0; v < NV; v++) begin
                    if (!done && m_wave[v]) begin
                        done = 1;
                        wk[v] = 1'b1;
                        m_code = 8'h60 | 8'(v);
                    end
                end
                for (int v = 0; v < NV; v++) begin
                    if (!done && m_ramp[v]) begin
                        done = 1;
                        rk[v] = 1'b1;
                        m_code = 8'h80 | 8'(v);
                    end
                end
                if (!done) m_code = 8'hE8;
            end
            m_wave  = (m_wave & ~wk) | ws;
            m_ramp  = (m_ramp & ~rk) | rs;
            m_other = ((m_other & ~ec) | es) & 8'h9F;
        end
        e.due  = 32'(cyc + 1);
        e.code = m_code;
        e.wack = wk;
        e.rack = rk;
        e.card = m_other | ((m_wave != '0) ? 8'h20 : 8'h00) | ((m_ramp != '0) ? 8'h40 : 8'h00);
        e.irq  = (e.card != 8'h00);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        drive('0, '0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, tag);
    endtask

    task automatic pop(input string tag);
        drive('0, '0, 1'b1, 8'h8F, 1'b0, 8'h00, 8'h00, tag);
    endtask

    // Monitor: compares the design's outputs against the queued expectations
    always @(negedge clk) begin
        if (exp_q.size() > 0 && exp_q[0].due == 32'(cyc)) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (irq_code !== e.code || wave_ack !== e.wack || ramp_ack !== e.rack ||
                card_irq_stat !== e.card || irq_out !== e.irq) begin
                failures++;
                $display("FAIL %s: actual code=%h wack=%h rack=%h card=%h irq=%b expected code=%h wack=%h rack=%h card=%h irq=%b",
                         t, irq_code, wave_ack, ramp_ack, card_irq_stat, irq_out,
                         e.code, e.wack, e.rack, e.card, e.irq);
            end
        end
    end

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (irq_code !== 8'hE8 || wave_ack !== '0 || ramp_ack !== '0 ||
            card_irq_stat !== 8'h00 || irq_out !== 1'b0) begin
            failures++;
            $display("FAIL R10: actual code=%h card=%h irq=%b expected code=e8 card=00 irq=0",
                     irq_code, card_irq_stat, irq_out);
        end

        idle("R10 idle");
        // Wave events on voices 3 and 17, ramp on voice 0
        drive((31'd1 << 3) | (31'd1 << 17), 31'd1, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, "R11 multi set");
        drive('0, '0, 1'b1, 8'h0F, 1'b0, 8'h00, 8'h00, "R1 other code");
        drive('0, '0, 1'b0, 8'h8F, 1'b0, 8'h00, 8'h00, "R1 no strobe");
        pop("R2 R3 wave voice 3 first");
        idle("R3 ack one cycle");
        pop("R3 wave voice 17");
        pop("R4 ramp voice 0");
        pop("R5 empty");
        idle("R7 line low");

        drive('0, '0, 1'b0, 8'h00, 1'b0, 8'h64, 8'h00, "R6 host set ignores 5/6");
        drive('0, '0, 1'b0, 8'h00, 1'b0, 8'h01, 8'h04, "R6 set and clear");
        drive('0, '0, 1'b0, 8'h00, 1'b0, 8'h02, 8'h02, "R6 set wins");
        drive('0, '0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h63, "R7 clear all");

        drive(31'd1 << 30, 31'd1 << 30, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, "R2 voice 30 set");
        pop("R2 voice 30 wave before ramp");
        drive('0, '0, 1'b0, 8'h00, 1'b0, 8'h10, 8'h00, "R7 host bit held");
        pop("R4 voice 30 ramp");
        idle("R7 irq held by host bit");
        drive('0, '0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h10, "R7 irq falls");

        drive(31'd1 << 5, '0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, "R9 set voice 5");
        drive(31'd1 << 5, '0, 1'b1, 8'h8F, 1'b0, 8'h00, 8'h00, "R9 set with pop");
        pop("R9 voice 5 again");
        pop("R9 now empty");

        drive(31'h7FFF_FFFF, 31'h0000_00F0, 1'b0, 8'h00, 1'b0, 8'h81, 8'h00, "R8 fill");
        drive(31'd1 << 2, 31'd1, 1'b1, 8'h8F, 1'b1, 8'h02, 8'h00, "R8 flush beats pop");
        pop("R8 nothing left");

        drive((31'd1 << 9) | (31'd1 << 1) | (31'd1 << 22), '0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, "R11 three voices");
        pop("R11 voice 1");
        pop("R11 voice 9");
        pop("R11 voice 22");
        idle("R11 drained");
        idle("final");

        repeat (3) @(negedge clk);
        report();
        $finish;
    end
endmodule